// File: doc/BRIEF.md
# Generation-Tagged Context Cache

This block keeps one cached 128-bit device context entry for each requester in a DMA remapping unit. A requester is named by a 16-bit source ID. Bits 15:8 are the bus and bits 7:0 are the devfn. Each slot holds the entry and a small generation tag. A lookup hits only when the slot's tag equals the block's current global generation. Tag value 0 always means empty.

Invalidations come from two sources, selected per request: a 64-bit register command word or a 128-bit queued descriptor. There are three granularities. Global and domain-selective requests both advance the global generation, which makes every slot stale in one cycle. Only when the counter would reach all ones does the block clear every tag and restart the generation at 1. A device-selective request clears the tags of the selected slots on one bus.

Every port is a valid-only stream with no back-pressure. A beat is taken in every cycle in which its valid is high. The result appears on the response outputs in the following cycle. A lookup answers from the state that held before the clock edge on which it was taken. A fill taken on the same edge does not affect that lookup.

Top module: `gcc_top`

## Requirements
- R1: A lookup taken at edge N gives `lk_rsp_vld`=1 after edge N. `lk_hit` is 1 only if the slot's tag equals the current generation, and `lk_entry` carries the stored entry on a hit and all zeros on a miss.
- R2: A fill with `fill_fault`=0 stores `fill_entry` and tags the slot with the current generation, so a later lookup hits with that entry. A fill with `fill_fault`=1 stores nothing.
- R3: After reset every lookup misses and the generation is 1.
- R4: A global invalidation makes every previously filled slot miss. When the incremented generation would equal all ones (width `GEN_W`), all tags are cleared and the generation returns to 1. Fills made after this wrap hit again.
- R5: A domain-selective request acts exactly like a global one, and reports actual granularity 1.
- R6: A device-selective request clears every slot whose bus equals the requested bus and whose devfn equals the requested devfn, ignoring some devfn bits. The function mask selects the ignored bits: 0 ignores none, 1 ignores bit 2, 2 ignores bits 2:1, 3 ignores bits 2:0. It reports actual granularity 3. Other slots keep hitting.
- R7: Register form (`inv_queued`=0) decodes `inv_lo` as follows:
  - granularity at bits 62:61 (1 global, 2 domain, 3 device)
  - source ID at bits 31:16
  - function mask at bits 33:32
  
  Granularity 0 gives `inv_err`=1 and `inv_actual`=0, and has no effect.
- R8: Queued form (`inv_queued`=1) decodes `inv_lo` as follows:
  - granularity at bits 5:4
  - source ID at bits 47:32
  - function mask at bits 49:48
  
  The request is rejected with `inv_err`=1, `inv_actual`=0 and no effect when any of these holds: `inv_lo & 64'hfffc00000000ffc0` is nonzero, `inv_hi` is nonzero, or the granularity is 0.
- R9: An invalidation that covers a slot wins over a fill to that slot on the same edge, so the slot reads back as a miss.
- R10: Slots exist only for bus < `BUS_SLOTS` and devfn < `DEVFN_SLOTS`. A fill to any other source ID is ignored, and a lookup of one misses.
- R11: `inv_done` pulses one cycle after each `inv_vld` beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vld | input | 1 | Lookup beat valid |
| lk_sid | input | 16 | Lookup source ID |
| lk_rsp_vld | output | 1 | Lookup response valid |
| lk_hit | output | 1 | Lookup hit |
| lk_entry | output | ENTRY_W | Cached entry on hit, zero on miss |
| fill_vld | input | 1 | Fill beat valid |
| fill_fault | input | 1 | Walk faulted, do not store |
| fill_sid | input | 16 | Fill source ID |
| fill_entry | input | ENTRY_W | Entry returned by the walker |
| inv_vld | input | 1 | Invalidation beat valid |
| inv_queued | input | 1 | 1: queued descriptor form, 0: register command form |
| inv_lo | input | 64 | Command word or descriptor low word |
| inv_hi | input | 64 | Descriptor high word (unused in register form) |
| inv_done | output | 1 | Invalidation response valid |
| inv_err | output | 1 | Request rejected |
| inv_actual | output | 2 | Actual granularity: 1 global, 3 device, 0 rejected |

## Verification
A generation counter that skips a value, fails to advance, or restarts without clearing the tags shows as a wrong hit or miss. The bad result appears on the first lookup of an affected slot, one cycle after that lookup is taken. The wrap path is the risky one, because a stale tag can match again after the counter restarts. With a 4-bit counter the wrap comes every 14 global requests, so a long mixed run reaches it many times. Device-selective masking errors appear as neighbouring devfns that hit when they should miss, or the reverse. The bench checks these by sweeping a whole bus after each mask value.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  typedef enum logic [1:0] {
    GR_NONE   = 2'd0,
    GR_GLOBAL = 2'd1,
    GR_DOMAIN = 2'd2,
    GR_DEVICE = 2'd3
  } gran_e;

  localparam logic [63:0] QD_RSVD_MASK = 64'hfffc00000000ffc0;

  // devfn bits that a device-selective request ignores
  function automatic logic [2:0] fm_ignore(input logic [1:0] fm);
    case (fm)
      2'd0:    fm_ignore = 3'b000;
      2'd1:    fm_ignore = 3'b100;
      2'd2:    fm_ignore = 3'b110;
      default: fm_ignore = 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/gcc_inv_decode.sv
module gcc_inv_decode
  import gcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inv_vld,
  input  logic        inv_queued,
  input  logic [63:0] inv_lo,
  input  logic [63:0] inv_hi,
  output logic        bump,
  output logic        dev_clr,
  output logic [7:0]  clr_bus,
  output logic [7:0]  clr_devfn,
  output logic [2:0]  clr_ign,
  output logic        inv_done,
  output logic        inv_err,
  output logic [1:0]  inv_actual
);
  gran_e       gran;
  logic [15:0] sid;
  logic [1:0]  fm;
  logic        bad;
  logic [1:0]  act;

  always_comb begin
    if (inv_queued) begin
      gran = gran_e'(inv_lo[5:4]);
      sid  = inv_lo[47:32];
      fm   = inv_lo[49:48];
      bad  = (|(inv_lo & QD_RSVD_MASK)) || (|inv_hi) || (gran == GR_NONE);
    end else begin
      gran = gran_e'(inv_lo[62:61]);
      sid  = inv_lo[31:16];
      fm   = inv_lo[33:32];
      bad  = (gran == GR_NONE);
    end
    bump      = inv_vld && !bad && (gran == GR_GLOBAL || gran == GR_DOMAIN);
    dev_clr   = inv_vld && !bad && (gran == GR_DEVICE);
    clr_bus   = sid[15:8];
    clr_devfn = sid[7:0];
    clr_ign   = fm_ignore(fm);
    act       = bad ? 2'd0 : ((gran == GR_DEVICE) ? 2'd3 : 2'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_done   <= 1'b0;
      inv_err    <= 1'b0;
      inv_actual <= 2'd0;
    end else begin
      inv_done   <= inv_vld;
      inv_err    <= inv_vld && bad;
      inv_actual <= inv_vld ? act : 2'd0;
    end
  end

  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_err |-> (inv_actual == 2'd0 && inv_done));
  assert_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld |=> inv_done);
endmodule

// File: rtl/gcc_gen_ctr.sv
module gcc_gen_ctr #(
  parameter int GEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [GEN_W-1:0] gen,
  output logic             flush
);
  localparam logic [GEN_W-1:0] GEN_ONE = GEN_W'(1);
  localparam logic [GEN_W-1:0] GEN_MAX = '1;

  assign flush = bump && ((gen + GEN_ONE) == GEN_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)     gen <= GEN_ONE;
    else if (flush) gen <= GEN_ONE;
    else if (bump)  gen <= gen + GEN_ONE;
  end

  assert_gen_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gen != '0) && (gen != GEN_MAX));
  assert_gen_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !flush) |=> (gen == $past(gen) + GEN_ONE));
  assert_gen_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (gen == GEN_ONE));
  assert_gen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(gen));
endmodule

// File: rtl/gcc_slot_array.sv
module gcc_slot_array #(
  parameter int BUS_SLOTS   = 2,
  parameter int DEVFN_SLOTS = 16,
  parameter int GEN_W       = 4,
  parameter int ENTRY_W     = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GEN_W-1:0]   gen,
  input  logic               flush,
  input  logic               dev_clr,
  input  logic [7:0]         clr_bus,
  input  logic [7:0]         clr_devfn,
  input  logic [2:0]         clr_ign,
  input  logic               fill_vld,
  input  logic               fill_fault,
  input  logic [15:0]        fill_sid,
  input  logic [ENTRY_W-1:0] fill_entry,
  input  logic               lk_vld,
  input  logic [15:0]        lk_sid,
  output logic               rsp_vld,
  output logic               rsp_hit,
  output logic [ENTRY_W-1:0] rsp_entry
);
  localparam int SLOTS = BUS_SLOTS * DEVFN_SLOTS;
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [GEN_W-1:0]   tag [SLOTS];
  logic [ENTRY_W-1:0] ent [SLOTS];
  logic [SLOTS-1:0]   clr_vec;
  logic [SLOTS-1:0]   wr_vec;
  logic [SLOTS-1:0]   live_vec;

  function automatic logic present(input logic [15:0] sid);
    present = (32'(sid[15:8]) < BUS_SLOTS) && (32'(sid[7:0]) < DEVFN_SLOTS);
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic [15:0] sid);
    slot_of = IDX_W'(32'(sid[15:8]) * DEVFN_SLOTS + 32'(sid[7:0]));
  endfunction

  logic             fill_ok;
  logic [IDX_W-1:0] fill_idx;
  logic             lk_ok;
  logic [IDX_W-1:0] lk_idx;

  assign fill_ok  = fill_vld && !fill_fault && present(fill_sid);
  assign fill_idx = present(fill_sid) ? slot_of(fill_sid) : '0;
  assign lk_ok    = present(lk_sid);
  assign lk_idx   = lk_ok ? slot_of(lk_sid) : '0;

  for (genvar b = 0; b < BUS_SLOTS; b++) begin : g_bus
    for (genvar d = 0; d < DEVFN_SLOTS; d++) begin : g_dev
      localparam int S = b * DEVFN_SLOTS + d;
      localparam logic [7:0] BUS_ID = 8'(b);
      localparam logic [7:0] DF_ID  = 8'(d);
      assign clr_vec[S] = flush ||
        (dev_clr && (clr_bus == BUS_ID) &&
         (((DF_ID ^ clr_devfn) & ~{5'b0, clr_ign}) == 8'd0));
      assign wr_vec[S]   = fill_ok && (fill_idx == IDX_W'(S));
      assign live_vec[S] = (tag[S] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) tag[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (clr_vec[s])     tag[s] <= '0;
        else if (wr_vec[s]) tag[s] <= gen;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++)
      if (wr_vec[s]) ent[s] <= fill_entry;
  end

  logic lk_hit_now;
  assign lk_hit_now = lk_vld && lk_ok && (tag[lk_idx] == gen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_entry <= '0;
    end else begin
      rsp_vld   <= lk_vld;
      rsp_hit   <= lk_hit_now;
      rsp_entry <= lk_hit_now ? ent[lk_idx] : '0;
    end
  end

  assert_flush_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (live_vec == '0));
  assert_fill_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && !clr_vec[fill_idx]) |=> (tag[$past(fill_idx)] == $past(gen)));
  assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_clr && fill_ok && clr_vec[fill_idx]) |=> (tag[$past(fill_idx)] == '0));
  assert_hit_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_vld);
  assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_entry == '0));
endmodule

// File: rtl/gcc_top.sv
module gcc_top #(
  parameter int BUS_SLOTS   = 2,
  parameter int DEVFN_SLOTS = 16,
  parameter int GEN_W       = 4,
  parameter int ENTRY_W     = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_vld,
  input  logic [15:0]        lk_sid,
  output logic               lk_rsp_vld,
  output logic               lk_hit,
  output logic [ENTRY_W-1:0] lk_entry,
  input  logic               fill_vld,
  input  logic               fill_fault,
  input  logic [15:0]        fill_sid,
  input  logic [ENTRY_W-1:0] fill_entry,
  input  logic               inv_vld,
  input  logic               inv_queued,
  input  logic [63:0]        inv_lo,
  input  logic [63:0]        inv_hi,
  output logic               inv_done,
  output logic               inv_err,
  output logic [1:0]         inv_actual
);
  logic             bump;
  logic             flush;
  logic             dev_clr;
  logic [7:0]       clr_bus;
  logic [7:0]       clr_devfn;
  logic [2:0]       clr_ign;
  logic [GEN_W-1:0] gen;

  gcc_inv_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_vld    (inv_vld),
    .inv_queued (inv_queued),
    .inv_lo     (inv_lo),
    .inv_hi     (inv_hi),
    .bump       (bump),
    .dev_clr    (dev_clr),
    .clr_bus    (clr_bus),
    .clr_devfn  (clr_devfn),
    .clr_ign    (clr_ign),
    .inv_done   (inv_done),
    .inv_err    (inv_err),
    .inv_actual (inv_actual)
  );

  gcc_gen_ctr #(.GEN_W(GEN_W)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (bump),
    .gen   (gen),
    .flush (flush)
  );

  gcc_slot_array #(
    .BUS_SLOTS   (BUS_SLOTS),
    .DEVFN_SLOTS (DEVFN_SLOTS),
    .GEN_W       (GEN_W),
    .ENTRY_W     (ENTRY_W)
  ) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen        (gen),
    .flush      (flush),
    .dev_clr    (dev_clr),
    .clr_bus    (clr_bus),
    .clr_devfn  (clr_devfn),
    .clr_ign    (clr_ign),
    .fill_vld   (fill_vld),
    .fill_fault (fill_fault),
    .fill_sid   (fill_sid),
    .fill_entry (fill_entry),
    .lk_vld     (lk_vld),
    .lk_sid     (lk_sid),
    .rsp_vld    (lk_rsp_vld),
    .rsp_hit    (lk_hit),
    .rsp_entry  (lk_entry)
  );
endmodule

// File: tb/test_gcc_top.sv
`timescale 1ns/1ps
module test_gcc_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lk_vld = 1'b0;
  logic [15:0]  lk_sid = '0;
  logic         lk_rsp_vld;
  logic         lk_hit;
  logic [127:0] lk_entry;
  logic         fill_vld = 1'b0;
  logic         fill_fault = 1'b0;
  logic [15:0]  fill_sid = '0;
  logic [127:0] fill_entry = '0;
  logic         inv_vld = 1'b0;
  logic         inv_queued = 1'b0;
  logic [63:0]  inv_lo = '0;
  logic [63:0]  inv_hi = '0;
  logic         inv_done;
  logic         inv_err;
  logic [1:0]   inv_actual;

  int checks = 0;
  int errors = 0;

  // reference model: explicit valid bits, bus 0..3, devfn 0..31
  bit           mv [0:3][0:31];
  logic [127:0] me [0:3][0:31];

  always #2 clk = ~clk;

  gcc_top i_gcc_top (
    .clk(clk), .rst_n(rst_n),
    .lk_vld(lk_vld), .lk_sid(lk_sid),
    .lk_rsp_vld(lk_rsp_vld), .lk_hit(lk_hit), .lk_entry(lk_entry),
    .fill_vld(fill_vld), .fill_fault(fill_fault), .fill_sid(fill_sid),
    .fill_entry(fill_entry),
    .inv_vld(inv_vld), .inv_queued(inv_queued), .inv_lo(inv_lo), .inv_hi(inv_hi),
    .inv_done(inv_done), .inv_err(inv_err), .inv_actual(inv_actual)
  );

  function automatic bit here(input logic [15:0] sid);
    return (sid[15:8] < 2) && (sid[7:0] < 16);
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // one clock with the currently driven inputs
  task automatic cyc(input string rq);
    bit e_hit;
    logic [127:0] e_ent;
    logic [1:0] g, fm;
    logic [15:0] s;
    bit bad;
    logic [2:0] ign;
    e_hit = lk_vld && here(lk_sid) && mv[lk_sid[9:8]][lk_sid[4:0]];
    e_ent = e_hit ? me[lk_sid[9:8]][lk_sid[4:0]] : '0;
    if (inv_queued) begin
      g = inv_lo[5:4]; s = inv_lo[47:32]; fm = inv_lo[49:48];
      bad = (inv_lo & 64'hfffc00000000ffc0) != 0 || inv_hi != 0 || g == 0;
    end else begin
      g = inv_lo[62:61]; s = inv_lo[31:16]; fm = inv_lo[33:32];
      bad = (g == 0);
    end
    ign = (fm == 0) ? 3'b000 : (fm == 1) ? 3'b100 : (fm == 2) ? 3'b110 : 3'b111;
    @(posedge clk);
    #1;
    chk(rq, "lk_rsp_vld", 128'(lk_rsp_vld), 128'(lk_vld));
    chk(rq, "lk_hit", 128'(lk_hit), 128'(e_hit));
    chk(rq, "lk_entry", lk_entry, e_ent);
    chk("R11", "inv_done", 128'(inv_done), 128'(inv_vld));
    chk(rq, "inv_err", 128'(inv_err), 128'(inv_vld && bad));
    chk(rq, "inv_actual", 128'(inv_actual),
        128'((inv_vld && !bad) ? ((g == 3) ? 2'd3 : 2'd1) : 2'd0));
    if (fill_vld && !fill_fault && here(fill_sid)) begin
      mv[fill_sid[9:8]][fill_sid[4:0]] = 1'b1;
      me[fill_sid[9:8]][fill_sid[4:0]] = fill_entry;
    end
    if (inv_vld && !bad) begin
      for (int b = 0; b < 2; b++)
        for (int d = 0; d < 16; d++)
          if (g != 3 || (b == int'(s[15:8]) &&
              ((8'(d) ^ s[7:0]) & ~{5'b0, ign}) == 0))
            mv[b][d] = 1'b0;
    end
    lk_vld = 0; fill_vld = 0; fill_fault = 0; inv_vld = 0;
    inv_queued = 0; inv_lo = '0; inv_hi = '0;
  endtask

  task automatic look(input string rq, input logic [15:0] sid);
    lk_vld = 1; lk_sid = sid; cyc(rq);
  endtask

  task automatic fill(input string rq, input logic [15:0] sid, input bit flt);
    fill_vld = 1; fill_sid = sid; fill_fault = flt;
    fill_entry = {$urandom, $urandom, $urandom, $urandom}; cyc(rq);
  endtask

  function automatic logic [63:0] regw(input logic [1:0] g, input logic [15:0] s,
                                       input logic [1:0] fm);
    return (64'(g) << 61) | (64'(fm) << 32) | (64'(s) << 16);
  endfunction

  function automatic logic [63:0] qdw(input logic [1:0] g, input logic [15:0] s,
                                      input logic [1:0] fm);
    return (64'(fm) << 48) | (64'(s) << 32) | (64'(g) << 4);
  endfunction

  task automatic inv(input string rq, input bit q, input logic [63:0] lo,
                     input logic [63:0] hi);
    inv_vld = 1; inv_queued = q; inv_lo = lo; inv_hi = hi; cyc(rq);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) for (int d = 0; d < 32; d++) mv[b][d] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3: empty after reset
    look("R3", 16'h0003);
    look("R3", 16'h010f);
    // R2: fill then hit; faulting fill stores nothing
    fill("R2", 16'h0105, 0);
    look("R2", 16'h0105);
    fill("R2", 16'h0106, 1);
    look("R2", 16'h0106);
    // R10: absent slots
    fill("R10", 16'h0220, 0);
    look("R10", 16'h0220);
    fill("R10", 16'h0011, 0);
    look("R10", 16'h0011);
    // R4: global invalidation, repeated past the counter wrap
    for (int i = 0; i < 20; i++) begin
      fill("R4", 16'(i % 16), 0);
      look("R4", 16'(i % 16));
      inv("R4", i[0], i[0] ? qdw(2'd1, 0, 0) : regw(2'd1, 0, 0), 0);
      look("R4", 16'(i % 16));
      look("R4", 16'h0105);
    end
    // R5: domain-selective behaves as global
    fill("R5", 16'h0002, 0);
    inv("R5", 1, qdw(2'd2, 16'h0002, 0) | 64'h0000_0000_1234_0000, 0);
    look("R5", 16'h0002);
    fill("R5", 16'h0003, 0);
    inv("R5", 0, regw(2'd2, 16'h0003, 0) | 64'h55, 0);
    look("R5", 16'h0003);
    // R6: device-selective with every mask value
    for (int fm = 0; fm < 4; fm++) begin
      for (int d = 0; d < 16; d++) fill("R6", {8'h01, 8'(d)}, 0);
      fill("R6", 16'h0004, 0);
      inv("R6", fm[0], fm[0] ? qdw(2'd3, 16'h010d, 2'(fm)) : regw(2'd3, 16'h010d, 2'(fm)), 0);
      for (int d = 0; d < 16; d++) look("R6", {8'h01, 8'(d)});
      look("R6", 16'h0004);
    end
    // R7: register form with granularity 0 rejected
    fill("R7", 16'h0007, 0);
    inv("R7", 0, regw(2'd0, 0, 0), 0);
    look("R7", 16'h0007);
    // R8: queued rejections have no effect
    inv("R8", 1, qdw(2'd1, 0, 0) | 64'h40, 0);
    look("R8", 16'h0007);
    inv("R8", 1, qdw(2'd1, 0, 0), 64'h1);
    look("R8", 16'h0007);
    inv("R8", 1, qdw(2'd0, 0, 0), 0);
    look("R8", 16'h0007);
    inv("R8", 1, qdw(2'd3, 16'h0007, 0) | (64'h1 << 50), 0);
    look("R8", 16'h0007);
    inv("R8", 1, qdw(2'd3, 16'h0007, 0), 0);
    look("R8", 16'h0007);
    // R9: invalidation beats a fill on the same edge
    fill_vld = 1; fill_sid = 16'h0108; fill_entry = '1;
    inv_vld = 1; inv_queued = 1; inv_lo = qdw(2'd3, 16'h0108, 0);
    cyc("R9");
    look("R9", 16'h0108);
    fill_vld = 1; fill_sid = 16'h0109; fill_entry = '1;
    inv_vld = 1; inv_lo = regw(2'd1, 0, 0);
    cyc("R9");
    look("R9", 16'h0109);
    // R1: random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] rs;
      lk_vld = ($urandom % 10) < 7;
      lk_sid = {8'($urandom % 3), 8'($urandom % 18)};
      fill_vld = ($urandom % 10) < 4;
      fill_fault = ($urandom % 7) == 0;
      fill_sid = {8'($urandom % 3), 8'($urandom % 18)};
      fill_entry = {$urandom, $urandom, $urandom, $urandom};
      if (($urandom % 12) == 0) begin
        rs = {8'($urandom % 3), 8'($urandom % 16)};
        inv_vld = 1;
        inv_queued = $urandom % 2;
        inv_lo = inv_queued ? qdw(2'($urandom), rs, 2'($urandom))
                            : regw(2'($urandom), rs, 2'($urandom));
        if (($urandom % 10) == 0) inv_lo[6] = 1'b1;
        if (($urandom % 10) == 0) inv_hi = 64'h8;
      end
      cyc("R1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule